// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a byte-addressed serial memory. It watches the SCL and SDA lines after synchronising them to a fast system clock. From them it recognises Start and Stop conditions and shifts in bytes on SCL rising edges. It answers through an open-drain pull-down output. A transaction opens with a control byte that carries a fixed device code, three select bits compared with strap inputs, and a direction bit. A write transaction then loads a 15-bit word pointer from two address bytes and passes every following data byte to a separate page-write unit. A read transaction streams bytes from a memory read port, starting at the pointer. When the page-write unit reports that a programming cycle is running, the block withholds every acknowledge.

The control state machine has these states. `ST_IDLE` waits for a Start. `ST_CTRL` receives the control byte, and `ST_CTRL_ACK` acknowledges it. `ST_AHI` with `ST_AHI_ACK` handles the high address byte, and `ST_ALO` with `ST_ALO_ACK` the low address byte. `ST_WDAT` and `ST_WDAT_ACK` handle write data. `ST_RDAT` sends a read byte, and `ST_RACK` samples the master's acknowledge. `ST_IGNORE` stays silent. The transitions are as follows. A Start enters `ST_CTRL` from any state, and a Stop enters `ST_IDLE` from any state. A byte state that has received eight bits moves on the next SCL fall to its acknowledge state, or to `ST_IGNORE` on a mismatch or while busy. An acknowledge state moves on its SCL fall to the next byte state: `ST_RDAT` or `ST_AHI` from `ST_CTRL_ACK`, `ST_ALO` from `ST_AHI_ACK`, and `ST_WDAT` from `ST_ALO_ACK` or `ST_WDAT_ACK`. `ST_RDAT` goes to `ST_RACK` after eight bits. `ST_RACK` returns to `ST_RDAT` on a master acknowledge, or goes to `ST_IGNORE` on a master no-acknowledge.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL stays high is a Start and begins control-byte reception. A rising SDA while SCL stays high is a Stop. A Stop returns the block to idle with SDA released, so bytes clocked afterwards without a new Start get no acknowledge.
- R2: A control byte is accepted when bits 7..4 equal 4'b1010 and bits 3..1 equal strap_sel[2:0]. Bit 0 selects the direction: 1 means read, 0 means write.
- R3: After a write control byte, the next two bytes form the pointer, high byte first. The pointer is {high[6:0], low[7:0]}, and bit 7 of the high byte is discarded.
- R4: Each accepted byte is acknowledged by pulling SDA low for the whole high phase of the ninth SCL pulse. SDA is released after that pulse falls. Out of reset, the pull-down is off.
- R5: If wr_busy is high when a byte completes, that byte (the control byte included) gets no acknowledge. The block then stays silent until the next Start.
- R6: Read bytes are sent MSB first, starting at the pointer, through rd_addr. The pointer increases by one after each byte and wraps from 7FFF to 0000.
- R7: A missing master acknowledge after a read byte ends the read. SDA stays released for any further SCL pulses until the next Start.
- R8: A control byte with a wrong device code or select field gets no acknowledge, and the block then ignores all bytes until the next Start.
- R9: Each write data byte is acknowledged and produces a one-cycle wr_valid carrying the pointer and the byte. The pointer then increases by one.
- R10: A Stop that ends a transaction which delivered at least one write data byte, with no Start in between, produces a one-cycle wr_commit. Other Stops produce none.
- R11: A Start at any bit position abandons the partial byte and restarts control-byte reception.
- R12: The SDA pull-down changes only in the cycle after a synchronised SCL fall, a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 leaves it released |
| strap_sel | input | 3 | Select-bit straps compared with control byte bits 3..1 |
| wr_busy | input | 1 | Programming cycle running; withholds acknowledges |
| rd_addr | output | 15 | Memory read address (current pointer) |
| rd_data | input | 8 | Memory read data for rd_addr, combinational |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 15 | Address of the write byte |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | One-cycle strobe at a Stop ending a write |

## Verification
Properties are checked on every cycle. They cover acknowledge gating against the busy input, launching pull-down changes only after an SCL fall or a bus condition, the return to control-byte reception with a cleared bit count after every Start, silence in the ignore state, and single-cycle write strobes. Other behaviour shows only in the bench's bus scenarios. These are the compare against the straps, the byte order of the address and its dropped top bit, the read data sequence and its wrap at the top of the space, the release after a master no-acknowledge, and the commit strobe appearing only for Stops that end a write with data. Randomised transactions mix strap values, addresses, directions and lengths against the bench's own memory function.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_IGNORE
    } sms_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    function automatic logic is_ack_st(sms_state_e s);
        return (s == ST_CTRL_ACK) || (s == ST_AHI_ACK) ||
               (s == ST_ALO_ACK)  || (s == ST_WDAT_ACK);
    endfunction

    function automatic logic is_byte_st(sms_state_e s);
        return (s == ST_CTRL) || (s == ST_AHI) || (s == ST_ALO) ||
               (s == ST_WDAT) || (s == ST_RDAT);
    endfunction

endpackage

// File: rtl/sms_line_sync.sv
`timescale 1ns/1ps
module sms_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/sms_cond_detect.sv
`timescale 1ns/1ps
module sms_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/sms_bit_engine.sv
`timescale 1ns/1ps
module sms_bit_engine #(
    parameter int WIDTH = 8,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_en_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] byte_o,
    output logic [CW-1:0]    cnt_o,
    output logic             full_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
            cnt_o  <= '0;
        end else if (clr_i) begin
            cnt_o  <= '0;
        end else if (shift_en_i && (cnt_o < CW'(WIDTH))) begin
            byte_o <= {byte_o[WIDTH-2:0], bit_i};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

    assign full_o = (cnt_o == CW'(WIDTH));

endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [2:0]        strap_sel,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    localparam int HI_W = ADDR_W - 8;
    localparam int CW   = $clog2(9);

    logic [1:0] raw_w;
    logic [1:0] sync_w;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] rx_byte;
    logic [CW-1:0] bit_cnt;
    logic       byte_full;
    logic       eng_clr, eng_shift;

    sms_state_e state_q, state_d;

    logic              sda_low_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        tx_q;
    logic              rw_q;
    logic              mack_q;
    logic              wr_seen_q;
    logic              wr_valid_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;
    logic              commit_q;
    logic              ctrl_match;

    assign raw_w = {scl_in, sda_in};

    sms_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_w),
        .sync_o (sync_w)
    );

    sms_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (sync_w[1]),
        .sda_i      (sync_w[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    assign eng_clr   = start_evt | stop_evt | (state_d != state_q);
    assign eng_shift = scl_rise & is_byte_st(state_q);

    sms_bit_engine #(.WIDTH(8)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (eng_clr),
        .shift_en_i (eng_shift),
        .bit_i      (sync_w[0]),
        .byte_o     (rx_byte),
        .cnt_o      (bit_cnt),
        .full_o     (byte_full)
    );

    assign ctrl_match = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == strap_sel);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_CTRL;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_CTRL:     if (byte_full) state_d = (ctrl_match && !wr_busy) ? ST_CTRL_ACK : ST_IGNORE;
                ST_CTRL_ACK: state_d = rw_q ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_full) state_d = wr_busy ? ST_IGNORE : ST_AHI_ACK;
                ST_AHI_ACK:  state_d = ST_ALO;
                ST_ALO:      if (byte_full) state_d = wr_busy ? ST_IGNORE : ST_ALO_ACK;
                ST_ALO_ACK:  state_d = ST_WDAT;
                ST_WDAT:     if (byte_full) state_d = wr_busy ? ST_IGNORE : ST_WDAT_ACK;
                ST_WDAT_ACK: state_d = ST_WDAT;
                ST_RDAT:     if (byte_full) state_d = ST_RACK;
                ST_RACK:     state_d = mack_q ? ST_RDAT : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low_q  <= 1'b0;
            ptr_q      <= '0;
            tx_q       <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            wr_seen_q  <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            commit_q   <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            commit_q   <= 1'b0;
            if (start_evt) begin
                sda_low_q <= 1'b0;
                wr_seen_q <= 1'b0;
            end else if (stop_evt) begin
                sda_low_q <= 1'b0;
                commit_q  <= wr_seen_q;
                wr_seen_q <= 1'b0;
            end else begin
                if (scl_rise && state_q == ST_RACK)
                    mack_q <= ~sync_w[0];
                if (scl_fall) begin
                    sda_low_q <= 1'b0;
                    if (state_d != state_q && is_ack_st(state_d))
                        sda_low_q <= 1'b1;
                    if (state_q == ST_CTRL && state_d == ST_CTRL_ACK)
                        rw_q <= rx_byte[0];
                    if (state_q == ST_AHI && state_d == ST_AHI_ACK)
                        ptr_q[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                    if (state_q == ST_ALO && state_d == ST_ALO_ACK)
                        ptr_q[7:0] <= rx_byte;
                    if (state_q == ST_WDAT && state_d == ST_WDAT_ACK) begin
                        wr_valid_q <= 1'b1;
                        wr_addr_q  <= ptr_q;
                        wr_data_q  <= rx_byte;
                        ptr_q      <= ptr_q + 1'b1;
                        wr_seen_q  <= 1'b1;
                    end
                    if (state_q == ST_RDAT && state_d == ST_RACK)
                        ptr_q <= ptr_q + 1'b1;
                    if (state_d == ST_RDAT && state_q != ST_RDAT) begin
                        tx_q      <= {rd_data[6:0], 1'b0};
                        sda_low_q <= ~rd_data[7];
                    end else if (state_q == ST_RDAT && state_d == ST_RDAT && bit_cnt != '0) begin
                        sda_low_q <= ~tx_q[7];
                        tx_q      <= {tx_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sda_pull_low = sda_low_q;
    assign rd_addr      = ptr_q;
    assign wr_valid     = wr_valid_q;
    assign wr_addr      = wr_addr_q;
    assign wr_data      = wr_data_q;
    assign wr_commit    = commit_q;

    // an acknowledge pull-down only begins when busy was low at the decision
    assert_ack_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_low_q) && is_ack_st(state_q)) |-> !$past(wr_busy));

    // pull-down moves only after a seen SCL fall or a bus condition
    assert_launch_after_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low_q != $past(sda_low_q)) |-> $past(scl_fall || start_evt || stop_evt));

    // a Start always restarts control-byte reception with an empty count
    assert_restart_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (state_q == ST_CTRL && bit_cnt == '0));

    // ignore state keeps the line released
    assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_low_q);

    // write strobes last one cycle
    assert_wr_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_q |=> !wr_valid_q);

endmodule

// File: tb/serial_mem_slave_tb.sv
`timescale 1ns/1ps
module serial_mem_slave_tb_top;

    localparam int Q = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        busy  = 1'b0;
    logic        pull;
    logic [14:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_valid;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit;
    logic        sda_line;

    assign sda_line = m_sda & ~pull;

    function automatic logic [7:0] mem_fn(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    assign rd_data = mem_fn(rd_addr);

    serial_mem_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_pull_low (pull),
        .strap_sel    (strap),
        .wr_busy      (busy),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_commit    (wr_commit)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [14:0] ev_addr [64];
    logic [7:0]  ev_data [64];
    int          ev_n = 0;
    int          commit_n = 0;
    int          launch_bad = 0;
    logic        scl_d = 1'b1;
    logic        pull_d = 1'b0;
    logic [7:0]  wbuf [4];

    always @(posedge clk) begin
        if (wr_valid) begin
            ev_addr[ev_n % 64] <= wr_addr;
            ev_data[ev_n % 64] <= wr_data;
            ev_n <= ev_n + 1;
        end
        if (wr_commit) commit_n <= commit_n + 1;
        scl_d  <= m_scl;
        pull_d <= pull;
        if (rst_n && m_scl && scl_d && (pull != pull_d)) launch_bad <= launch_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
    endtask

    // acked = line low at both ends of the ninth high phase; rel = released after it
    task automatic send_byte(input logic [7:0] b, output bit acked, output bit rel);
        bit s0, s1;
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(1);
        s0 = !sda_line; wq(2*Q - 2);
        s1 = !sda_line; wq(1);
        m_scl = 1'b0; wq(Q);
        acked = s0 && s1;
        rel   = !pull;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = mack ? 1'b0 : 1'b1; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    task automatic run_write(input logic [2:0] sel, input logic [14:0] a, input int n,
                             input bit topbit);
        bit ak, rl;
        int acks = 0;
        int rels = 0;
        int base = ev_n;
        int c0 = commit_n;
        bus_start();
        send_byte({4'b1010, sel, 1'b0}, ak, rl); acks += ak; rels += rl;
        send_byte({topbit, a[14:8]}, ak, rl);    acks += ak; rels += rl;
        send_byte(a[7:0], ak, rl);               acks += ak; rels += rl;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak, rl); acks += ak; rels += rl;
        end
        bus_stop(); wq(4);
        chk(acks == 3 + n, "R2 R4 write acks", acks, 3 + n);
        chk(rels == 3 + n, "R4 release after ninth pulse", rels, 3 + n);
        chk(ev_n == base + n, "R9 write strobe count", ev_n - base, n);
        for (int i = 0; i < n; i++) begin
            logic [14:0] ea = a + 15'(i);
            chk(ev_addr[(base + i) % 64] == ea, "R3 R9 write address", ev_addr[(base + i) % 64], ea);
            chk(ev_data[(base + i) % 64] == wbuf[i], "R9 write data", ev_data[(base + i) % 64], wbuf[i]);
        end
        chk(commit_n == c0 + ((n > 0) ? 1 : 0), "R10 commit count", commit_n - c0, (n > 0) ? 1 : 0);
    endtask

    task automatic run_read(input logic [2:0] sel, input logic [14:0] a, input int n,
                            input bit extra);
        bit ak, rl;
        int acks = 0;
        logic [7:0] b;
        int pulls = 0;
        bus_start();
        send_byte({4'b1010, sel, 1'b0}, ak, rl); acks += ak;
        send_byte({1'b0, a[14:8]}, ak, rl);      acks += ak;
        send_byte(a[7:0], ak, rl);               acks += ak;
        bus_start();
        send_byte({4'b1010, sel, 1'b1}, ak, rl); acks += ak;
        chk(acks == 4, "R11 R2 read setup acks after repeated start", acks, 4);
        for (int i = 0; i < n; i++) begin
            logic [14:0] ea = a + 15'(i);
            recv_byte(b, i < n - 1);
            chk(b == mem_fn(ea), "R6 read data", b, mem_fn(ea));
        end
        if (extra) begin
            for (int k = 0; k < 3; k++) begin
                wq(Q); m_scl = 1'b1;
                for (int j = 0; j < 2*Q; j++) begin wq(1); if (pull) pulls++; end
                m_scl = 1'b0; wq(Q);
            end
            chk(pulls == 0, "R7 released after master no-ack", pulls, 0);
        end
        bus_stop(); wq(4);
    endtask

    initial begin
        bit ak, rl;
        int base, c0;
        logic [14:0] ra;
        void'($urandom(32'h5EED_1234));
        wq(5);
        rst_n = 1'b1;
        wq(3);
        chk(pull == 1'b0, "R4 reset pull-down off", pull, 0);
        chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R9 R10 reset strobes low", {wr_valid, wr_commit}, 0);

        // directed write with top address bit set
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        run_write(3'b101, 15'h4310, 3, 1'b1);

        // address only, no data: no commit
        run_write(3'b101, 15'h0100, 0, 1'b0);

        // read across the top of the space with released line after no-ack
        run_read(3'b101, 15'h7FFE, 3, 1'b1);

        // wrong device code
        base = ev_n; c0 = commit_n;
        bus_start();
        send_byte(8'h2A, ak, rl);
        chk(!ak, "R8 wrong code not acked", ak, 0);
        send_byte(8'h00, ak, rl);
        chk(!ak, "R8 bytes ignored after mismatch", ak, 0);
        send_byte(8'h55, ak, rl);
        bus_stop(); wq(4);
        chk(ev_n == base && commit_n == c0, "R8 no write after mismatch", ev_n - base, 0);

        // wrong select straps
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, ak, rl);
        chk(!ak, "R2 R8 strap mismatch not acked", ak, 0);
        bus_stop();

        // busy during control byte
        busy = 1'b1;
        bus_start();
        send_byte({4'b1010, 3'b101, 1'b0}, ak, rl);
        chk(!ak, "R5 busy control byte not acked", ak, 0);
        bus_stop();
        busy = 1'b0;

        // busy arriving before a data byte
        base = ev_n; c0 = commit_n;
        bus_start();
        send_byte({4'b1010, 3'b101, 1'b0}, ak, rl);
        send_byte(8'h01, ak, rl);
        send_byte(8'h02, ak, rl);
        busy = 1'b1;
        send_byte(8'h77, ak, rl);
        chk(!ak, "R5 busy data byte not acked", ak, 0);
        bus_stop(); wq(4);
        busy = 1'b0;
        chk(ev_n == base && commit_n == c0, "R5 R10 no write while busy", ev_n - base, 0);

        // Stop returns to idle: a byte without Start is not acked
        bus_start();
        send_byte({4'b1010, 3'b101, 1'b0}, ak, rl);
        bus_stop();
        send_byte({4'b1010, 3'b101, 1'b0}, ak, rl);
        chk(!ak, "R1 no ack without Start after Stop", ak, 0);
        bus_stop();

        // repeated Start in the middle of a control byte
        bus_start();
        send_bits(8'hA6, 4);
        wbuf[0] = 8'hC4;
        run_write(3'b101, 15'h2222, 1, 1'b0);
        chk(commit_n > 0, "R11 R1 transaction after aborted byte", commit_n, 1);

        // randomised transactions
        for (int it = 0; it < 22; it++) begin
            int n = 1 + ($urandom % 4);
            strap = 3'($urandom);
            ra = 15'($urandom);
            if ($urandom % 2) begin
                for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
                run_write(strap, ra, n, 1'($urandom));
            end else begin
                run_read(strap, ra, n, 1'b0);
            end
        end

        chk(launch_bad == 0, "R12 no pull-down change while SCL high", launch_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule